// File: doc/BRIEF.md
# Rising-Edge Interrupt Collector

This block collects a set of asynchronous interrupt lines and presents one registered, glitch-free interrupt request to a single processor context. Every line first passes through a two-flop synchronizer. A rising edge on the synchronized line then sets a sticky pending bit. The bit stays set after the line falls, so a short pulse from a peripheral still gets serviced.

Software sees two 32-bit registers on a simple single-cycle read/write bus. The first is a per-source enable mask. The second is a claim/complete register. A read of the claim register hands out the lowest-numbered source that is both enabled and pending. A write of the same ID ends the service of that source. Priority is fixed by index. There are no priority levels, no thresholds and only one context.

A two-state machine tracks the claim. In `ST_IDLE` the output request follows the enabled pending bits. A claim read that finds a winner takes the CLAIM_TAKEN transition to `ST_CLAIMED`. In `ST_CLAIMED` the request is held low. Only a completion write that carries the held ID takes the COMPLETE_OK transition back to `ST_IDLE`. Every other bus access leaves the state where it is.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the enable mask is 0, no source is pending or in service, `ext_irq` is 0 and a claim read returns 0.
- R2: Offset 0x0 holds the enable mask. Bit i enables source i for i < NUM_IRQS. The register is written and read back whole, and bits at or above NUM_IRQS always read 0.
- R3: A rising edge on `irq_in[i]` sets pending bit i on the third rising clock edge after the input changes. A pulse that lasts at least two clock cycles is kept after the line falls.
- R4: Only rising edges count. A line held high does not set pending again, and a falling edge has no effect.
- R5: `ext_irq` is 1 exactly when some source is both enabled and pending and no claim is outstanding.
- R6: A read at offset 0x4 with no claim outstanding returns ID = i+1 for the lowest-numbered enabled pending source i. The same read clears pending bit i, marks source i in service and makes `ext_irq` 0 from the next cycle on.
- R7: A claim read that finds no enabled pending source returns 0 and changes no state.
- R8: While a claim is outstanding, a claim read returns 0 and changes no state.
- R9: A write at offset 0x4 whose data equals the outstanding ID ends the claim. Any other enabled pending source then raises `ext_irq` on the next cycle.
- R10: A write at offset 0x4 whose data differs from the outstanding ID, or that arrives when no claim is outstanding, is ignored.
- R11: Rising edges on a source that is in service are dropped. They are not latched and cannot be claimed after completion.
- R12: A disabled source still latches its edge as pending. Once enabled, it raises `ext_irq` and can be claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_IRQS | Asynchronous interrupt lines, one per source |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ext_irq | output | 1 | Synchronous interrupt request to the core |

## Verification
A wrong pending or in-service bit shows up on the next claim read. The wrong source wins or gets lost, and the returned ID is off at once. It also shows on `ext_irq` one cycle after the claim or completion that should have changed it. A stuck state machine shows the same cycle: `ext_irq` stays low after a matching completion, or a second claim read returns a nonzero ID. Edge-detection faults appear three clocks after a line changes, as a missing or repeated request. That is why every check of `ext_irq` is sampled after that latency.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned OFS_ENABLE = 0;
    localparam int unsigned OFS_CLAIM  = 4;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CLAIMED = 1'b1
    } claim_state_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int unsigned NUM_IRQS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] lines,
    output logic [NUM_IRQS-1:0] rise
);
    for (genvar g = 0; g < NUM_IRQS; g++) begin : g_src
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= lines[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise[g] = sync_q & ~last_q;

        // R3: an edge strobe lasts exactly one cycle
        assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned NUM_IRQS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] rise,
    input  logic [NUM_IRQS-1:0] take,
    input  logic                release_all,
    output logic [NUM_IRQS-1:0] pending,
    output logic [NUM_IRQS-1:0] in_service
);
    logic [NUM_IRQS-1:0] pending_n, service_n;

    always_comb begin
        pending_n = (pending | (rise & ~in_service)) & ~take;
        service_n = (in_service | take) & ~{NUM_IRQS{release_all}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= '0;
            in_service <= '0;
        end else begin
            pending    <= pending_n;
            in_service <= service_n;
        end
    end

    // R6: at most one source is in service
    assert_one_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_service));

    // R11: an in-service source never holds a pending bit
    assert_no_pend_in_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & in_service) == '0);
endmodule

// File: rtl/irq_claim_fsm.sv
module irq_claim_fsm
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_IRQS = 8,
    parameter int unsigned ID_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_claim,
    input  logic                wr_claim,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_IRQS-1:0] ready,
    output logic [ID_W-1:0]     claim_id,
    output logic [NUM_IRQS-1:0] take,
    output logic                release_all,
    output logic                ext_irq,
    output claim_state_e        state
);
    claim_state_e        state_n;
    logic [ID_W-1:0]     held_id;
    logic [ID_W-1:0]     win_id;
    logic [NUM_IRQS-1:0] win_hot;
    logic                any_ready;
    logic                id_match;

    // lowest index wins: scan downwards so the last hit is the smallest index
    always_comb begin
        win_id  = '0;
        win_hot = '0;
        for (int i = NUM_IRQS - 1; i >= 0; i--) begin
            if (ready[i]) begin
                win_id  = ID_W'(i + 1);
                win_hot = '0;
                win_hot[i] = 1'b1;
            end
        end
    end

    assign any_ready = |ready;
    assign id_match  = (wdata == REG_W'(held_id));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            held_id <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && rd_claim && any_ready) begin
                held_id <= win_id;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_n     = state;
        claim_id    = '0;
        take        = '0;
        release_all = 1'b0;
        ext_irq     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ext_irq  = any_ready;
                claim_id = win_id;
                if (rd_claim && any_ready) begin
                    take    = win_hot;
                    state_n = ST_CLAIMED;   // CLAIM_TAKEN
                end
            end
            ST_CLAIMED: begin
                if (wr_claim && id_match) begin
                    release_all = 1'b1;
                    state_n     = ST_IDLE;  // COMPLETE_OK
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R10: a wrong completion ID leaves the claim outstanding
    assert_bad_id_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLAIMED && wr_claim && !id_match) |=> state == ST_CLAIMED);

    // R8: a claim read while a claim is outstanding does not change the state
    assert_reclaim_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLAIMED && rd_claim) |=> state == ST_CLAIMED);
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_IRQS = 8,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQS-1:0] irq_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                ext_irq
);
    localparam int unsigned ID_W = $clog2(NUM_IRQS + 1);

    logic [NUM_IRQS-1:0] rise, take, pending, in_service, enable_q;
    logic                release_all;
    logic [ID_W-1:0]     claim_id;
    claim_state_e        state;
    logic                hit_enable, hit_claim;
    logic                rd_claim, wr_claim;

    assign hit_enable = (bus_addr == ADDR_W'(OFS_ENABLE));
    assign hit_claim  = (bus_addr == ADDR_W'(OFS_CLAIM));
    assign rd_claim   = bus_sel && !bus_wr && hit_claim;
    assign wr_claim   = bus_sel &&  bus_wr && hit_claim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (bus_sel && bus_wr && hit_enable) begin
            enable_q <= bus_wdata[NUM_IRQS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_enable) bus_rdata = REG_W'(enable_q);
            else if (hit_claim) bus_rdata = REG_W'(claim_id);
        end
    end

    irq_sync_edge #(.NUM_IRQS(NUM_IRQS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise)
    );

    irq_pend_bank #(.NUM_IRQS(NUM_IRQS)) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .take        (take),
        .release_all (release_all),
        .pending     (pending),
        .in_service  (in_service)
    );

    irq_claim_fsm #(.NUM_IRQS(NUM_IRQS), .ID_W(ID_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_claim    (rd_claim),
        .wr_claim    (wr_claim),
        .wdata       (bus_wdata),
        .ready       (pending & enable_q),
        .claim_id    (claim_id),
        .take        (take),
        .release_all (release_all),
        .ext_irq     (ext_irq),
        .state       (state)
    );

    // R6: a successful claim drops the request on the next cycle
    assert_claim_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim && bus_rdata != '0) |=> !ext_irq);

    // R5: the claim state and the in-service bits agree
    assert_state_matches_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLAIMED) == (in_service != '0));
endmodule

// File: tb/test_irq_edge_ctrl.sv
module test_irq_edge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 8;
    localparam logic [1:0] OP_NONE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [31:0] tag;
        logic [7:0]  lines;
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } step_t;

    localparam int NSTEPS = 17;
    localparam step_t STEPS [NSTEPS] = '{
        '{"R2",  8'h00, OP_WR,   4'h0, 32'h0000_00FF, 32'h0, 1'b0},
        '{"R2",  8'h00, OP_RD,   4'h0, 32'h0,         32'h0000_00FF, 1'b0},
        '{"R2",  8'h00, OP_WR,   4'h0, 32'hFFFF_FFFF, 32'h0, 1'b0},
        '{"R2",  8'h00, OP_RD,   4'h0, 32'h0,         32'h0000_00FF, 1'b0},
        '{"R5",  8'h24, OP_NONE, 4'h0, 32'h0,         32'h0, 1'b1},
        '{"R6",  8'h00, OP_RD,   4'h4, 32'h0,         32'h3, 1'b0},
        '{"R8",  8'h00, OP_RD,   4'h4, 32'h0,         32'h0, 1'b0},
        '{"R10", 8'h00, OP_WR,   4'h4, 32'h6,         32'h0, 1'b0},
        '{"R9",  8'h04, OP_WR,   4'h4, 32'h3,         32'h0, 1'b1},
        '{"R11", 8'h04, OP_RD,   4'h4, 32'h0,         32'h6, 1'b0},
        '{"R4",  8'h04, OP_WR,   4'h4, 32'h6,         32'h0, 1'b0},
        '{"R7",  8'h04, OP_RD,   4'h4, 32'h0,         32'h0, 1'b0},
        '{"R4",  8'h00, OP_NONE, 4'h0, 32'h0,         32'h0, 1'b0},
        '{"R12", 8'h80, OP_WR,   4'h0, 32'h0000_0001, 32'h0, 1'b0},
        '{"R12", 8'h80, OP_WR,   4'h0, 32'h0000_0080, 32'h0, 1'b1},
        '{"R6",  8'h80, OP_RD,   4'h4, 32'h0,         32'h8, 1'b0},
        '{"R9",  8'h00, OP_WR,   4'h4, 32'h8,         32'h0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq_in = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            ext_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_edge_ctrl #(.NUM_IRQS(NIRQ), .ADDR_W(4)) i_irq_edge_ctrl (
        .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ext_irq (ext_irq)
    );

    task automatic check(input logic [31:0] tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one bus access at a falling edge; returns read data seen before the next rising edge
    task automatic bus_op(input logic [1:0] op, input logic [3:0] addr,
                          input logic [31:0] wdata, output logic [31:0] rd);
        rd = '0;
        if (op != OP_NONE) begin
            bus_sel = 1'b1; bus_wr = (op == OP_WR); bus_addr = addr; bus_wdata = wdata;
            #1 rd = bus_rdata;
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        #1 check("R1", 32'(ext_irq), 32'd0);
        bus_op(OP_RD, 4'h0, 32'h0, rd);
        check("R1", rd, 32'h0);
        bus_op(OP_RD, 4'h4, 32'h0, rd);
        check("R1", rd, 32'h0);

        // table walk: set lines, wait for the three-flop path, do the access, check
        for (int k = 0; k < NSTEPS; k++) begin
            irq_in = STEPS[k].lines;
            repeat (3) @(negedge clk);
            bus_op(STEPS[k].op, STEPS[k].addr, STEPS[k].wdata, rd);
            if (STEPS[k].op == OP_RD) check(STEPS[k].tag, rd, STEPS[k].exp_rd);
            check(STEPS[k].tag, 32'(ext_irq), 32'(STEPS[k].exp_irq));
        end

        // R3: two-cycle pulse on source 1 is kept after it falls
        bus_op(OP_WR, 4'h0, 32'h0000_00FF, rd);
        irq_in = 8'h02;
        repeat (2) @(negedge clk);
        irq_in = 8'h00;
        check("R3", 32'(ext_irq), 32'd0);
        repeat (2) @(negedge clk);
        #1 check("R3", 32'(ext_irq), 32'd1);
        bus_op(OP_RD, 4'h4, 32'h0, rd);
        check("R3", rd, 32'h2);
        bus_op(OP_WR, 4'h4, 32'h2, rd);

        // R3: exact latency, pending appears at the third rising edge
        irq_in = 8'h01;
        repeat (2) @(negedge clk);
        #1 check("R3", 32'(ext_irq), 32'd0);
        @(negedge clk);
        #1 check("R3", 32'(ext_irq), 32'd1);

        // R10: completion write when idle has no effect
        bus_op(OP_WR, 4'h4, 32'h1, rd);
        check("R10", 32'(ext_irq), 32'd1);
        bus_op(OP_RD, 4'h4, 32'h0, rd);
        check("R6", rd, 32'h1);
        bus_op(OP_WR, 4'h4, 32'h1, rd);
        check("R9", 32'(ext_irq), 32'd0);

        finish_run();
    end
endmodule